// File: doc/BRIEF.md
# Audio PWM DAC Output Core

This core turns 16-bit PCM audio samples into pulse-width-modulated output pins, one for each channel. Software or a DMA engine writes samples into a write-data word. In stereo builds each 32-bit word carries a left and a right sample. In mono builds each word carries one sample in its low half. A valid/ready handshake on that word stalls the writer while the core still holds a sample it has not used.

A control word sets the following:
- the run state;
- an 8-bit or 10-bit PWM period;
- where the pulse sits inside the period: left, right or centre;
- how many periods each sample is repeated for;
- an optional flip of the sample's sign bit, which turns two's complement into offset binary;
- a left pre-shift of 0 to 7 bits.

The conditioned sample's upper 8 or 10 bits become the compare value for the channel. A new compare value is taken only at a period boundary, so the pulse never glitches.

Top module: `pwmdac_core`

## Requirements
- R1: After reset the control word at offset 0x04 reads 0x00004008. Written control values read back in bits 17:0. Bits above 17, and any other read address, read as zero.
- R2: While control bit 0 (run) is clear, every pwm_o bit is low. No buffered sample is consumed, so a full buffer keeps wr_ready low for offset 0x00.
- R3: Control bit 1 selects the period. With bit 1 = 0 the period is 256 cycles and the compare value is conditioned-sample bits 15:8. With bit 1 = 1 the period is 1024 cycles and the compare value is bits 15:6.
- R4: Control bits 3:2 select the pulse position, with compare value C and period P. Code 0: the output is high in cycles 0..C-1 of the period. Code 1: high in cycles P-C..P-1. Codes 2 and 3: high in cycles L..L+C-1, where L = floor((P-C)/2).
- R5: Control bits 12:4 hold H, and each accepted sample drives H+1 consecutive periods.
- R6: Control bit 14 set inverts sample bit 15 before use. Bit 14 clear uses the sample unchanged.
- R7: Control bits 17:15 give a left shift S of 0 to 7, applied after the bit-14 step and truncated to 16 bits.
- R8: A stereo data word drives channel 0 from bits 15:0 and channel 1 from bits 31:16. A mono build uses bits 15:0 only.
- R9: The core holds one pending sample. A write to offset 0x00 is taken only when wr_en and wr_ready are both high. wr_ready is low for offset 0x00 while a sample is pending, and control writes are always taken.
- R10: The compare value changes only at a period boundary. The first period after run is set is low. The pending sample loads at the first boundary and then at each sample end. If no sample is pending at a sample end, the last sample repeats.
- R11: Control bit 13 is stored and read back but has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write valid |
| wr_addr | input | ADDR_W | Write byte offset (0x00 samples, 0x04 control) |
| wr_data | input | DATA_W | Write data |
| wr_ready | output | 1 | Write can be taken this cycle |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Read data (combinational) |
| pwm_o | output | NUM_CH | PWM output, one bit per channel |

## Verification
The assertions assume that the writer holds wr_addr and wr_data steady while wr_en is high and wr_ready is low. They also assume that the period and run settings change only through control writes and never between the reset and the first edge. The bench keeps within these limits by driving the bus only on falling edges. It waits on wr_ready before moving on, and it changes the configuration only while run is clear. Because the writer keeps the buffer full, the bench can predict the expected compare sequence exactly: one zero period, then each sample for H+1 periods, then the last sample repeated.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;

   localparam int unsigned SMP_W     = 16;
   localparam int unsigned HOLD_W    = 9;
   localparam int unsigned SHIFT_W   = 3;
   localparam int unsigned CTRL_BITS = 18;

   typedef enum logic [1:0] {
      POS_LEFT    = 2'd0,
      POS_RIGHT   = 2'd1,
      POS_CENTRE  = 2'd2,
      POS_CENTRE2 = 2'd3
   } pulse_pos_e;

   // Field positions are fixed by software, so packed MSB first.
   typedef struct packed {
      logic [SHIFT_W-1:0] pre_shift;   // 17:15
      logic               sign_flip;   // 14
      logic               keep_flag;   // 13
      logic [HOLD_W-1:0]  hold_m1;     // 12:4
      pulse_pos_e         pos;         // 3:2
      logic               wide;        // 1
      logic               run;         // 0
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{
      pre_shift: '0, sign_flip: 1'b1, keep_flag: 1'b0,
      hold_m1: '0, pos: POS_CENTRE, wide: 1'b0, run: 1'b0};

endpackage

// File: rtl/pwmdac_regs.sv
module pwmdac_regs
   import pwmdac_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned DATA_OFF = 0,
   parameter int unsigned CTRL_OFF = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   output logic                    wr_ready,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [DATA_W-1:0]       rd_data,
   input  logic                    take,
   output ctrl_t                   cfg,
   output logic                    buf_full,
   output logic [NUM_CH*SMP_W-1:0] buf_q
);

   localparam int unsigned BUF_W = NUM_CH * SMP_W;
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFF);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFF);

   logic hit_data, hit_ctrl, acc_data, acc_ctrl;

   assign hit_data = (wr_addr == A_DATA);
   assign hit_ctrl = (wr_addr == A_CTRL);
   assign wr_ready = !(hit_data && buf_full);
   assign acc_data = wr_en && hit_data && !buf_full;
   assign acc_ctrl = wr_en && hit_ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= CTRL_RESET;
      end else if (acc_ctrl) begin
         cfg <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_full <= 1'b0;
         buf_q    <= '0;
      end else if (acc_data) begin
         buf_full <= 1'b1;
         buf_q    <= wr_data[BUF_W-1:0];
      end else if (take) begin
         buf_full <= 1'b0;
      end
   end

   logic unused_hi_bits;
   generate
      if (DATA_W > BUF_W) begin : g_spare
         assign unused_hi_bits = ^{wr_data[DATA_W-1:BUF_W], wr_data[CTRL_BITS-1:0]};
      end else begin : g_nospare
         assign unused_hi_bits = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL) rd_data[CTRL_BITS-1:0] = cfg;
   end

   // R9: a pending sample is never overwritten before it is used
   assert_buf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full && !take) |=> (buf_full && $stable(buf_q)));

endmodule

// File: rtl/pwmdac_timebase.sv
module pwmdac_timebase
   import pwmdac_pkg::*;
#(
   parameter int unsigned LO_RES = 8,
   parameter int unsigned HI_RES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wide,
   input  logic [HOLD_W-1:0] hold_m1,
   output logic [HI_RES-1:0] cnt,
   output logic              period_end,
   output logic              sample_end
);

   localparam logic [HI_RES-1:0] TOP_LO = HI_RES'((1 << LO_RES) - 1);
   localparam logic [HI_RES-1:0] TOP_HI = HI_RES'((1 << HI_RES) - 1);

   logic [HI_RES-1:0] top;
   logic [HOLD_W-1:0] rep;

   assign top        = wide ? TOP_HI : TOP_LO;
   assign period_end = run && (cnt >= top);
   assign sample_end = period_end && (rep >= hold_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         rep <= '1;
      end else if (!run) begin
         cnt <= '0;
         rep <= '1;   // first boundary after run counts as a sample end
      end else if (period_end) begin
         cnt <= '0;
         rep <= sample_end ? '0 : rep + 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R3: the period counter restarts after its last cycle
   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> (cnt == '0));

   // R5: a sample end only happens once the hold count is used up
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && period_end && !sample_end) |=> (rep != '0));

endmodule

// File: rtl/pwmdac_channel.sv
module pwmdac_channel
   import pwmdac_pkg::*;
#(
   parameter int unsigned LO_RES = 8,
   parameter int unsigned HI_RES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              load,
   input  logic [SMP_W-1:0]  sample,
   input  ctrl_t             cfg,
   input  logic [HI_RES-1:0] cnt,
   output logic              pwm
);

   localparam int unsigned EXT_W = HI_RES + 1;
   localparam logic [EXT_W-1:0] LEN_LO = EXT_W'(1 << LO_RES);
   localparam logic [EXT_W-1:0] LEN_HI = EXT_W'(1 << HI_RES);

   logic [SMP_W-1:0]  flipped, shifted;
   logic [HI_RES-1:0] next_cmp, cmp_q;
   logic [EXT_W-1:0]  p_len, cnt_x, cmp_x, c_lo, c_hi;
   logic              hit;

   // sample conditioning
   assign flipped = sample ^ {cfg.sign_flip, {(SMP_W-1){1'b0}}};
   assign shifted = flipped << cfg.pre_shift;

   always_comb begin
      if (cfg.wide) next_cmp = shifted[SMP_W-1 -: HI_RES];
      else          next_cmp = HI_RES'(shifted[SMP_W-1 -: LO_RES]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cmp_q <= '0;
      else if (!run) cmp_q <= '0;
      else if (load) cmp_q <= next_cmp;
   end

   // comparator
   assign p_len = cfg.wide ? LEN_HI : LEN_LO;
   assign cnt_x = {1'b0, cnt};
   assign cmp_x = {1'b0, cmp_q};
   assign c_lo  = (p_len - cmp_x) >> 1;
   assign c_hi  = c_lo + cmp_x;

   always_comb begin
      unique case (cfg.pos)
         POS_LEFT:  hit = (cnt_x < cmp_x);
         POS_RIGHT: hit = ((cnt_x + cmp_x) >= p_len);
         default:   hit = (cnt_x >= c_lo) && (cnt_x < c_hi);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm <= 1'b0;
      else        pwm <= run && hit;
   end

   // R10: compare value changes only at a load
   assert_cmp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |=> $stable(cmp_q));

   // R2: stopped channel drives low
   assert_idle_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pwm);

endmodule

// File: rtl/pwmdac_core.sv
module pwmdac_core
   import pwmdac_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned LO_RES = 8,
   parameter int unsigned HI_RES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_CH-1:0] pwm_o
);

   localparam int unsigned BUF_W = NUM_CH * SMP_W;

   generate
      if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
         $error("pwmdac_core: NUM_CH must be 1 or 2");
      end
      if (BUF_W > DATA_W || DATA_W < CTRL_BITS) begin : g_bad_dw
         $error("pwmdac_core: DATA_W too narrow");
      end
      if (LO_RES >= HI_RES || HI_RES > SMP_W) begin : g_bad_res
         $error("pwmdac_core: need LO_RES < HI_RES <= 16");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("pwmdac_core: ADDR_W must reach offset 4");
      end
   endgenerate

   ctrl_t             cfg;
   logic              buf_full, take, period_end, sample_end;
   logic [BUF_W-1:0]  buf_q;
   logic [HI_RES-1:0] cnt;

   assign take = sample_end && buf_full;

   pwmdac_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH),
      .DATA_OFF(0), .CTRL_OFF(4)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_ready(wr_ready), .rd_addr(rd_addr),
      .rd_data(rd_data), .take(take), .cfg(cfg), .buf_full(buf_full),
      .buf_q(buf_q)
   );

   pwmdac_timebase #(.LO_RES(LO_RES), .HI_RES(HI_RES)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(cfg.run), .wide(cfg.wide),
      .hold_m1(cfg.hold_m1), .cnt(cnt), .period_end(period_end),
      .sample_end(sample_end)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         pwmdac_channel #(.LO_RES(LO_RES), .HI_RES(HI_RES)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(cfg.run), .load(take),
            .sample(buf_q[ch*SMP_W +: SMP_W]), .cfg(cfg), .cnt(cnt),
            .pwm(pwm_o[ch])
         );
      end
   endgenerate

   // R10: a buffered sample is only consumed on a period boundary
   assert_take_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full && cfg.run && !period_end) |=> buf_full);

endmodule

// File: tb/sim_pwmdac_core.sv
module sim_pwmdac_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        wr_ready;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [1:0]  pwm_o;

   int checks = 0;
   int fails  = 0;
   int q0[$];
   int q1[$];
   logic [31:0] smp[8];

   always #2 clk = ~clk;

   pwmdac_core u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_ready(wr_ready), .rd_addr(rd_addr),
      .rd_data(rd_data), .pwm_o(pwm_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mkcfg(int sh, int flip, int keep, int hm1, int pos, int wide, int run);
      return 32'((sh << 15) | (flip << 14) | (keep << 13) | (hm1 << 4) | (pos << 2) | (wide << 1) | run);
   endfunction

   function automatic int exp_cmp(logic [15:0] s, int flip, int sh, int wide);
      logic [15:0] v;
      v = flip ? (s ^ 16'h8000) : s;
      v = v << sh;
      return wide ? int'(v >> 6) : int'(v >> 8);
   endfunction

   function automatic bit exp_bit(int k, int c, int pos, int p);
      int lo;
      if (pos == 0) return k < c;
      if (pos == 1) return k >= p - c;
      lo = (p - c) / 2;
      return (k >= lo) && (k < lo + c);
   endfunction

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic send(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h00; wr_data = d;
      #1;
      while (!wr_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: push expected compare values as each sample is accepted
   task automatic drive(input int n, input int reps, input int flip, input int sh, input int wide);
      for (int i = 1; i < n; i++) begin
         send(smp[i]);
         for (int r = 0; r < reps; r++) begin
            q0.push_back(exp_cmp(smp[i][15:0], flip, sh, wide));
            q1.push_back(exp_cmp(smp[i][31:16], flip, sh, wide));
         end
      end
   endtask

   // monitor: pop per period, compare every cycle of both channels
   task automatic monitor(input int periods, input int pos, input int p, input string tag);
      int last0 = 0, last1 = 0;
      for (int per = 0; per < periods; per++) begin
         int c0, c1, bad0, bad1, hi0, hi1;
         c0 = (q0.size() > 0) ? q0.pop_front() : last0;
         c1 = (q1.size() > 0) ? q1.pop_front() : last1;
         last0 = c0; last1 = c1;
         bad0 = 0; bad1 = 0; hi0 = 0; hi1 = 0;
         for (int k = 0; k < p; k++) begin
            @(negedge clk);
            if (pwm_o[0] !== exp_bit(k, c0, pos, p)) bad0++;
            if (pwm_o[1] !== exp_bit(k, c1, pos, p)) bad1++;
            hi0 += int'(pwm_o[0]);
            hi1 += int'(pwm_o[1]);
         end
         chk(bad0 == 0, {tag, " ch0 high cycles"}, hi0, c0);
         chk(bad1 == 0, {tag, " ch1 high cycles"}, hi1, c1);
      end
   endtask

   task automatic scenario(input int sh, input int flip, input int keep, input int hm1,
                           input int pos, input int wide, input int n, input string tag);
      int idle_bad;
      logic [31:0] c;
      c = mkcfg(sh, flip, keep, hm1, pos, wide, 0);
      reg_write(8'h04, c);
      q0.delete(); q1.delete();
      send(smp[0]);
      // R2: stopped core keeps the pending sample and drives low
      wr_addr = 8'h00;
      idle_bad = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (wr_ready !== 1'b0 || pwm_o !== 2'b00) idle_bad++;
      end
      chk(idle_bad == 0, "R2 idle hold", idle_bad, 0);
      // R10: first period is low, then sample 0 for hm1+1 periods
      q0.push_back(0); q1.push_back(0);
      for (int r = 0; r <= hm1; r++) begin
         q0.push_back(exp_cmp(smp[0][15:0], flip, sh, wide));
         q1.push_back(exp_cmp(smp[0][31:16], flip, sh, wide));
      end
      reg_write(8'h04, c | 32'h1);
      fork
         drive(n, hm1 + 1, flip, sh, wide);
         monitor(1 + n * (hm1 + 1) + 2, pos, wide ? 1024 : 256, tag);
      join
      reg_write(8'h04, c);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      smp[0] = 32'hF000_1234;
      smp[1] = 32'h7FFF_8000;
      smp[2] = 32'h0100_C3A5;
      smp[3] = 32'h8001_0FF0;
      smp[4] = 32'h2222_FFFF;
      smp[5] = 32'h5A5A_0000;
      smp[6] = 32'hABCD_4321;
      smp[7] = 32'h0000_7F00;

      repeat (3) @(negedge clk);
      // R1 / R2: reset state
      rd_addr = 8'h04; #1;
      chk(rd_data == 32'h0000_4008, "R1 reset ctrl", rd_data, 32'h4008);
      chk(pwm_o == 2'b00, "R2 outputs low in reset", pwm_o, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(rd_data == 32'h0000_4008, "R1 ctrl after reset", rd_data, 32'h4008);
      wr_addr = 8'h00; #1;
      chk(wr_ready == 1'b1, "R9 empty buffer ready", wr_ready, 1);

      // R1 / R11: upper bits masked, bit 13 stored
      reg_write(8'h04, 32'hFFFF_FFFE);
      rd_addr = 8'h04; #1;
      chk(rd_data == 32'h0003_FFFE, "R1 R11 readback", rd_data, 32'h3FFFE);
      rd_addr = 8'h00; #1;
      chk(rd_data == 32'h0, "R1 other address reads zero", rd_data, 0);
      rd_addr = 8'h04;

      // R5 R6 R8 R9 R10: left, flip on, two periods per sample
      scenario(0, 1, 0, 1, 0, 0, 4, "R4-left R5 R6 R8 R9 R10");
      // R4 R6: right aligned, flip off, one period per sample
      scenario(0, 0, 0, 0, 1, 0, 4, "R4-right R6");
      // R4 R7: centre via code 3, shift 3
      scenario(3, 1, 0, 0, 3, 0, 4, "R4-centre R7");
      // R3: 10-bit periods, centre code 2, shift 1
      scenario(1, 1, 0, 0, 2, 1, 3, "R3 wide");
      // R11: bit 13 set gives the same waveform as the left case
      scenario(0, 1, 1, 1, 0, 0, 3, "R11 flag ignored");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule